// File: doc/BRIEF.md
# Auto-Incrementing Debug RAM Read Window

This block gives software a way to look inside the lookup-table RAMs of a translation unit without a dedicated memory-mapped aperture per array. It exposes two 32-bit registers on a small register bus. The first is a writable read pointer that names a source array, a way, an entry index and a word inside that entry. The second is a read-only data window that returns the word the pointer currently names.

Every read of the window has a side effect: once the access completes, the pointer steps forward by one word. A debugger therefore sets the pointer once and then streams an entire entry, or a run of entries, with repeated reads of the same address.

The block drives a one-cycle-latency synchronous read port toward the arrays. It returns zero for locations past the end of the selected array. Accesses that do not carry the secure qualifier are refused: they read as zero, their writes are dropped, and they never move the pointer.

Top module: `dbgw_top`

## Requirements
- R1: After a synchronous active-low reset, `resp_ready` and `arr_rd_en` are low and the pointer reads back as 0x00000000.
- R2: A secure write to byte offset 0x80 stores bits [27:26] (source), [25:24] (way) and [15:2] (entry and word). A read of 0x80 returns those bits, with bits [31:28], [23:16] and [1:0] always zero.
- R3: A secure read of byte offset 0x84 raises `arr_rd_en` in the request cycle. In that cycle the array port carries source = pointer[27:26], way = pointer[25:24], index = pointer[15:4] and word = pointer[3:2]. The response then returns the array's `arr_rdata` from the following cycle.
- R4: Every request, whether read or write and whatever its offset or qualifier, is answered by `resp_ready` high for exactly the next cycle, and `resp_ready` is low otherwise. Writes and unmapped offsets answer with data zero.
- R5: When a secure read of 0x84 completes, pointer bits [15:2] increase by one as a single 14-bit counter, and source and way stay unchanged. Word 3 of an entry is followed by word 0 of the next entry, and 0xFFFC wraps to 0x0000.
- R6: An entry index at or above the depth of the selected source (64, 64, 32 and 32 for sources 0 to 3) reads as zero, with `arr_rd_en` kept low, and the pointer still advances.
- R7: A request with `req_secure` low reads as zero, leaves the pointer unchanged when it is a write, keeps `arr_rd_en` low, and does not advance the pointer.
- R8: Writes to 0x84 are ignored and do not move the pointer. Reads of any offset other than 0x80 and 0x84 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure-domain qualifier of the request |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| resp_ready | output | 1 | Completion pulse, one cycle after the request |
| resp_rdata | output | 32 | Read data, valid while resp_ready is high, zero otherwise |
| arr_rd_en | output | 1 | Read strobe toward the target arrays |
| arr_src | output | 2 | Source array select |
| arr_way | output | 2 | Way select |
| arr_index | output | 12 | Entry index |
| arr_word | output | 2 | Word within the entry |
| arr_rdata | input | 32 | Array read data, one cycle after arr_rd_en |

## Verification
The assertions assume that a request lasts one cycle and that no new request arrives in the cycle that follows it. They also assume that `arr_rdata` holds the addressed word in the cycle after `arr_rd_en`. The bench drives each request for a single cycle and waits for the completion cycle before the next one, so requests are always at least two cycles apart. Its array model registers a value computed from source, way, index and word only when the read strobe is high, so each word in a stream can be told apart from the others.

// File: rtl/dbgw_pkg.sv
// Package: shared pointer layout and helpers for the debug read window.
// Assumes: entry index in pointer bits [15:4], word in [3:2].
package dbgw_pkg;
    localparam int IDX_W  = 12;
    localparam int WORD_W = 2;
    localparam int CTR_W  = IDX_W + WORD_W;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PREF = 2'd1,
        SRC_IPA  = 2'd2,
        SRC_WALK = 2'd3
    } src_e;

    typedef struct packed {
        logic [1:0]       src;
        logic [1:0]       way;
        logic [CTR_W-1:0] ctr;
    } ptr_t;

    // Build the 32-bit software view of the pointer, reserved bits zero.
    function automatic logic [31:0] ptr_image(input ptr_t p);
        return {4'b0, p.src, p.way, 8'b0, p.ctr, 2'b0};
    endfunction
endpackage

// File: rtl/dbgw_ptr_reg.sv
// Module: holds the read pointer; loads on write, steps one word on advance.
// Assumes: wr_en and inc_en never both high (one outstanding access).
module dbgw_ptr_reg
    import dbgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        inc_en,
    output ptr_t        ptr
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[31:28], wr_data[23:16], wr_data[1:0]};

    // Pointer storage: reset, software load, or post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_en) begin
            ptr.src <= wr_data[27:26];
            ptr.way <= wr_data[25:24];
            ptr.ctr <= wr_data[15:2];
        end else if (inc_en) begin
            ptr.ctr <= ptr.ctr + CTR_W'(1);
        end
    end

    // R5: one-word step, source and way untouched
    p_step_one_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !wr_en) |=> (ptr.ctr == $past(ptr.ctr) + CTR_W'(1))
                               && $stable(ptr.src) && $stable(ptr.way));

    // R7: with no load and no advance the pointer holds
    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !wr_en) |=> $stable(ptr));
endmodule

// File: rtl/dbgw_bounds.sv
// Module: decides whether an entry index lies inside the selected source array.
// Assumes: each depth is at most 2**IDX_W.
module dbgw_bounds
    import dbgw_pkg::*;
#(
    parameter int DEPTH0 = 64,
    parameter int DEPTH1 = 64,
    parameter int DEPTH2 = 32,
    parameter int DEPTH3 = 32
) (
    input  logic [1:0]       src,
    input  logic [IDX_W-1:0] idx,
    output logic             in_range
);
    localparam int NSRC = 4;
    localparam int DEPTHS [NSRC] = '{DEPTH0, DEPTH1, DEPTH2, DEPTH3};

    logic [NSRC-1:0] fits;

    // One comparator per source array.
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign fits[g] = {1'b0, idx} < (IDX_W+1)'(DEPTHS[g]);
    end

    // Select the comparison for the addressed source.
    always_comb in_range = fits[src];
endmodule

// File: rtl/dbgw_resp.sv
// Module: response stage; answers every request one cycle later and picks
// array data or a held register value. Also produces the advance strobe.
// Assumes: at most one request in flight.
module dbgw_resp (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_fire,
    input  logic        take_arr,
    input  logic        adv_in,
    input  logic [31:0] hold_in,
    input  logic [31:0] arr_rdata,
    output logic        resp_ready,
    output logic [31:0] resp_rdata,
    output logic        adv_out
);
    logic        ready_q;
    logic        sel_q;
    logic        adv_q;
    logic [31:0] hold_q;

    // Capture what the completion cycle must return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            sel_q   <= 1'b0;
            adv_q   <= 1'b0;
            hold_q  <= '0;
        end else begin
            ready_q <= req_fire;
            sel_q   <= req_fire & take_arr;
            adv_q   <= req_fire & adv_in;
            hold_q  <= req_fire ? hold_in : '0;
        end
    end

    // Drive the bus side only during completion.
    always_comb begin
        resp_ready = ready_q;
        resp_rdata = ready_q ? (sel_q ? arr_rdata : hold_q) : '0;
        adv_out    = ready_q & adv_q;
    end

    // R4: completion follows a request one cycle later
    p_ready_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> resp_ready);

    // R4: no completion without a request
    p_no_spurious_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_fire |=> !resp_ready);

    // R4: input assumption, single-cycle requests spaced apart
    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> !req_fire);
endmodule

// File: rtl/dbgw_top.sv
// Module: debug read window top; decodes the pointer and data registers,
// gates by security, checks bounds and drives the array read port.
// Assumes: requests are one cycle long and at least two cycles apart.
module dbgw_top
    import dbgw_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  PTR_OFS = 8'h80,
    parameter int          DEPTH0  = 64,
    parameter int          DEPTH1  = 64,
    parameter int          DEPTH2  = 32,
    parameter int          DEPTH3  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              resp_ready,
    output logic [31:0]       resp_rdata,
    output logic              arr_rd_en,
    output logic [1:0]        arr_src,
    output logic [1:0]        arr_way,
    output logic [IDX_W-1:0]  arr_index,
    output logic [WORD_W-1:0] arr_word,
    input  logic [31:0]       arr_rdata
);
    localparam logic [ADDR_W-1:0] PTR_ADDR = ADDR_W'(PTR_OFS);
    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(PTR_OFS + 8'd4);

    ptr_t        ptr;
    logic        hit_ptr, hit_dat, sec_req;
    logic        ptr_wr, ptr_rd, dat_rd, oob_rd, in_range, adv;
    logic [31:0] hold_val;

    // Address decode and security gating.
    always_comb begin
        hit_ptr  = (req_addr == PTR_ADDR);
        hit_dat  = (req_addr == DAT_ADDR);
        sec_req  = req_valid & req_secure;
        ptr_wr   = sec_req &  req_write & hit_ptr;
        ptr_rd   = sec_req & ~req_write & hit_ptr;
        dat_rd   = sec_req & ~req_write & hit_dat;
        oob_rd   = dat_rd & ~in_range;
        hold_val = ptr_rd ? ptr_image(ptr) : '0;
    end

    // Array read port follows the pointer fields.
    always_comb begin
        arr_src   = ptr.src;
        arr_way   = ptr.way;
        arr_index = ptr.ctr[CTR_W-1:WORD_W];
        arr_word  = ptr.ctr[WORD_W-1:0];
        arr_rd_en = dat_rd & in_range;
    end

    dbgw_ptr_reg u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ptr_wr),
        .wr_data (req_wdata),
        .inc_en  (adv),
        .ptr     (ptr)
    );

    dbgw_bounds #(
        .DEPTH0 (DEPTH0),
        .DEPTH1 (DEPTH1),
        .DEPTH2 (DEPTH2),
        .DEPTH3 (DEPTH3)
    ) u_bounds (
        .src      (ptr.src),
        .idx      (ptr.ctr[CTR_W-1:WORD_W]),
        .in_range (in_range)
    );

    dbgw_resp u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_valid),
        .take_arr   (arr_rd_en),
        .adv_in     (dat_rd),
        .hold_in    (hold_val),
        .arr_rdata  (arr_rdata),
        .resp_ready (resp_ready),
        .resp_rdata (resp_rdata),
        .adv_out    (adv)
    );

    // R6: out-of-bounds window read completes with zero
    p_oob_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oob_rd |=> (resp_ready && resp_rdata == 32'd0));

    // R7: non-secure access completes with zero
    p_nonsecure_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_secure) |=> (resp_ready && resp_rdata == 32'd0));

    // R2: pointer read-back keeps reserved and low bits clear
    p_ptr_image_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rd |=> (resp_rdata[31:28] == 4'd0 && resp_rdata[23:16] == 8'd0
                    && resp_rdata[1:0] == 2'd0));

    // R3: array read strobe only for a secure read of the window
    p_strobe_secure_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_en |-> (req_valid && req_secure && !req_write));
endmodule

// File: tb/sim_dbgw_top.sv
`timescale 1ns/100ps
module sim_dbgw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_ready, arr_rd_en;
    logic [31:0] resp_rdata;
    logic [1:0]  arr_src, arr_way, arr_word;
    logic [11:0] arr_index;
    logic [31:0] arr_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dbgw_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_ready(resp_ready), .resp_rdata(resp_rdata), .arr_rd_en(arr_rd_en),
        .arr_src(arr_src), .arr_way(arr_way), .arr_index(arr_index),
        .arr_word(arr_word), .arr_rdata(arr_rdata)
    );

    // Array model: one-cycle latency, word value tagged by its address.
    always @(posedge clk)
        if (arr_rd_en)
            arr_rdata <= 32'hB000_0000 | ({30'd0, arr_src} << 26) | ({30'd0, arr_way} << 24)
                         | ({20'd0, arr_index} << 12) | ({30'd0, arr_word} << 2);

    typedef struct packed {
        logic [3:0]  rq;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic        sec;
        logic [31:0] exp;
        logic        en;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        {4'd2, 1'b1, 8'h80, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0}, // R2 load 0
        {4'd3, 1'b0, 8'h84, 32'h0,         1'b1, 32'hB000_0000, 1'b1}, // R3
        {4'd5, 1'b0, 8'h84, 32'h0,         1'b1, 32'hB000_0004, 1'b1}, // R5
        {4'd5, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0000_0008, 1'b0}, // R5
        {4'd2, 1'b1, 8'h80, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R2
        {4'd2, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0F00_FFFC, 1'b0}, // R2 clean
        {4'd6, 1'b0, 8'h84, 32'h0,         1'b1, 32'h0000_0000, 1'b0}, // R6
        {4'd5, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0F00_0000, 1'b0}, // R5 wrap
        {4'd3, 1'b0, 8'h84, 32'h0,         1'b1, 32'hBF00_0000, 1'b1}, // R3
        {4'd2, 1'b1, 8'h80, 32'h0600_03FC, 1'b1, 32'h0000_0000, 1'b0}, // R2
        {4'd3, 1'b0, 8'h84, 32'h0,         1'b1, 32'hB603_F00C, 1'b1}, // R3
        {4'd5, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0600_0400, 1'b0}, // R5 next entry
        {4'd6, 1'b0, 8'h84, 32'h0,         1'b1, 32'h0000_0000, 1'b0}, // R6 idx 64
        {4'd2, 1'b1, 8'h80, 32'h0800_01F0, 1'b1, 32'h0000_0000, 1'b0}, // R2
        {4'd3, 1'b0, 8'h84, 32'h0,         1'b1, 32'hB801_F000, 1'b1}, // R3
        {4'd5, 1'b0, 8'h84, 32'h0,         1'b1, 32'hB801_F004, 1'b1}, // R5
        {4'd7, 1'b0, 8'h84, 32'h0,         1'b0, 32'h0000_0000, 1'b0}, // R7
        {4'd7, 1'b0, 8'h80, 32'h0,         1'b0, 32'h0000_0000, 1'b0}, // R7
        {4'd7, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0800_01F8, 1'b0}, // R7 no step
        {4'd7, 1'b1, 8'h80, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R7
        {4'd7, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0800_01F8, 1'b0}, // R7 unchanged
        {4'd8, 1'b1, 8'h84, 32'h1234_5678, 1'b1, 32'h0000_0000, 1'b0}, // R8
        {4'd8, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0800_01F8, 1'b0}, // R8
        {4'd8, 1'b0, 8'h88, 32'h0,         1'b1, 32'h0000_0000, 1'b0}, // R8
        {4'd2, 1'b1, 8'h80, 32'h0800_01FC, 1'b1, 32'h0000_0000, 1'b0}, // R2
        {4'd3, 1'b0, 8'h84, 32'h0,         1'b1, 32'hB801_F00C, 1'b1}, // R3
        {4'd5, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0800_0200, 1'b0}, // R5
        {4'd6, 1'b0, 8'h84, 32'h0,         1'b1, 32'h0000_0000, 1'b0}, // R6 idx 32
        {4'd2, 1'b1, 8'h80, 32'hF3FF_0017, 1'b1, 32'h0000_0000, 1'b0}, // R2
        {4'd2, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0300_0014, 1'b0}, // R2 reserved
        {4'd3, 1'b0, 8'h84, 32'h0,         1'b1, 32'hB300_1004, 1'b1}, // R3
        {4'd5, 1'b0, 8'h80, 32'h0,         1'b1, 32'h0300_0018, 1'b0}  // R5
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One bus access: request at a falling edge, completion sampled one cycle later.
    task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                          input logic sec, output logic [31:0] rd, output logic rdy,
                          output logic en);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_secure = sec;
        #1 en = arr_rd_en;
        @(negedge clk);
        rdy = resp_ready;
        rd  = resp_rdata;
        req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        logic rdy, en;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!resp_ready && !arr_rd_en, "R1 idle outputs in reset", {30'd0, resp_ready, arr_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!resp_ready, "R1 no completion after reset", {31'd0, resp_ready}, 32'd0);
        bus_op(1'b0, 8'h80, 32'h0, 1'b1, rd, rdy, en);
        check(rdy && rd == 32'd0, "R1 pointer zero after reset", rd, 32'd0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].wr, VEC[i].addr, VEC[i].wd, VEC[i].sec, rd, rdy, en);
            n_vec++;
            if (!(rdy && rd == VEC[i].exp && en == VEC[i].en)) begin
                n_bad++;
                $display("FAIL R%0d vector %0d actual=%08h rdy=%0d en=%0d expected=%08h en=%0d",
                         VEC[i].rq, i, rd, rdy, en, VEC[i].exp, VEC[i].en);
            end
        end

        // R4: completion lasts one cycle only
        @(negedge clk);
        check(!resp_ready && resp_rdata == 32'd0, "R4 ready drops after completion", resp_rdata, 32'd0);

        // R1: reset in the middle of use clears the pointer
        bus_op(1'b1, 8'h80, 32'h0C00_0100, 1'b1, rd, rdy, en);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_op(1'b0, 8'h80, 32'h0, 1'b1, rd, rdy, en);
        check(rdy && rd == 32'd0, "R1 pointer cleared by reset", rd, 32'd0);
        bus_op(1'b0, 8'h84, 32'h0, 1'b1, rd, rdy, en);
        check(rdy && en && rd == 32'hB000_0000, "R3 word 0 after reset", rd, 32'hB000_0000);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule